// File: doc/BRIEF.md
# Host Port Memory-Access Bridge

This block is a slave port that gives an external host processor a window into an on-chip word memory over an asynchronous 16-bit parallel bus. The host bus has an active-low chip select, read and write strobes, and two register-select lines. Behind those two lines sit four word registers: a memory data window, a mailbox, a byte pointer and a status word.

To move a block of memory, the host loads the pointer once and then streams words through the data register. The pointer advances by one word after every data access. Reads are served from a prefetch buffer, so the host never waits on the memory. The memory side is a request/grant port that the bridge holds until it receives a grant.

A two-way mailbox carries messages between the host and an internal processor. A word posted by the internal side raises an interrupt line and a status flag, and the host clears both by reading the mailbox. A word written by the host raises an "incoming full" flag and a one-cycle strobe on the internal side, and the internal side clears the flag with an acknowledge. An optional mode swaps the two bytes of every word that passes between the host bus and memory.

Top module: `hostport_bridge`

## Requirements
- R1: After reset, `host_rdata` is 0, `host_int` is 0, `mem_req` is 0, and the status register reads 0.
- R2: `host_addr` selects a 16-bit register: 2'b00 data window, 2'b01 mailbox, 2'b10 pointer, 2'b11 status. Status bit 0 is "outgoing mailbox full", bit 1 is "incoming mailbox full", and bits 15:2 read 0.
- R3: The strobes are active low and pass through a synchronizer. One access takes place on the leading edge of each strobe assertion, only while `host_cs_n` is low. Holding a strobe low longer does not repeat the access. A strobe with `host_cs_n` high has no effect.
- R4: A data-register write stores the host word to memory word `ptr[15:1]`. The pointer advances by 2 once the write is granted. `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_gnt`.
- R5: A data-register read returns the prefetched word at the pointer. The pointer then advances by 2, and the word at the new pointer is fetched. A pointer write also triggers a fetch. Consecutive reads therefore return consecutive memory words.
- R6: Reading the status register or the pointer register leaves the pointer unchanged.
- R7: A `cpu_out_wr` pulse stores `cpu_out_data` in the outgoing mailbox, sets status bit 0 and asserts `host_int`.
- R8: A host read of the mailbox register returns the outgoing word and clears status bit 0 and `host_int`. If a new post arrives in the same cycle, the post wins.
- R9: A host write of the mailbox register places the word on `cpu_in_word`, sets status bit 1 and pulses `cpu_in_stb` for exactly one cycle. `cpu_in_ack` clears status bit 1.
- R10: While `swap_en` is 1, the high and low bytes are exchanged on both the data written to memory and the data read from memory. While it is 0, words pass unchanged.
- R11: The pointer wraps from 16'hFFFE to 16'h0000 on increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_addr | input | 2 | Register select |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, captured at the read event |
| host_int | output | 1 | Outgoing-mailbox interrupt |
| swap_en | input | 1 | Byte-swap mode for memory data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with grant |
| mem_gnt | input | 1 | Memory grant |
| cpu_out_wr | input | 1 | Internal side posts an outgoing word |
| cpu_out_data | input | 16 | Outgoing mailbox word |
| cpu_in_word | output | 16 | Incoming mailbox word |
| cpu_in_stb | output | 1 | One-cycle pulse on a host mailbox write |
| cpu_in_ack | input | 1 | Internal side acknowledges the incoming word |

## Verification
The assertions check on every cycle that each strobe edge gives a single event and that a pending memory request holds its address and direction until grant. They also check that the pointer steps by exactly two after a granted write or an accepted read, that a status read leaves the pointer alone, and that the mailbox flags and incoming strobe respond one cycle after their causes. Only the bench's scenarios can show end-to-end results. These are that streamed words land at the right memory locations and come back in order, that prefetch hides grant latency, that byte swapping works in both directions, that the pointer wraps, and that a strobe without chip select does nothing.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
    localparam int HW    = 16;        // host word width
    localparam int MAW   = HW - 1;    // memory word address width
    localparam int BYTEW = HW / 2;

    typedef enum logic [1:0] {
        SEL_DATA = 2'b00,
        SEL_MBX  = 2'b01,
        SEL_PTR  = 2'b10,
        SEL_STAT = 2'b11
    } hpb_sel_e;

    typedef enum logic [1:0] {
        MP_IDLE,
        MP_WRITE,
        MP_FETCH
    } mp_state_e;

    typedef struct packed {
        logic cs_n;
        logic rd_n;
        logic wr_n;
    } hpb_strobe_t;

    typedef struct packed {
        logic rd;
        logic wr;
    } hpb_event_t;

    function automatic logic [HW-1:0] lane_swap(input logic [HW-1:0] w, input logic en);
        return en ? {w[BYTEW-1:0], w[HW-1:BYTEW]} : w;
    endfunction

    function automatic logic [HW-1:0] status_word(input logic out_full, input logic in_full);
        return {{(HW-2){1'b0}}, in_full, out_full};
    endfunction
endpackage

// File: rtl/hpb_sync.sv
module hpb_sync
    import hpb_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  hpb_strobe_t strobe_in,
    output hpb_event_t  ev
);
    hpb_strobe_t chain [STAGES];
    hpb_event_t  active, active_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                chain[g] <= '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1};
            end else if (g == 0) begin
                chain[g] <= strobe_in;
            end else begin
                chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    end

    always_comb begin
        active.rd = !chain[STAGES-1].cs_n && !chain[STAGES-1].rd_n;
        active.wr = !chain[STAGES-1].cs_n && !chain[STAGES-1].wr_n;
    end

    always_ff @(posedge clk) begin
        if (rst) active_q <= '0;
        else     active_q <= active;
    end

    assign ev.rd = active.rd && !active_q.rd;
    assign ev.wr = active.wr && !active_q.wr;

    // R3: one event per strobe assertion
    a_r3_single_rd: assert property (@(posedge clk) disable iff (rst) ev.rd |=> !ev.rd);
    a_r3_single_wr: assert property (@(posedge clk) disable iff (rst) ev.wr |=> !ev.wr);
endmodule

// File: rtl/hpb_mailbox.sv
module hpb_mailbox
    import hpb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          host_rd_ev,
    input  logic          host_wr_ev,
    input  logic [HW-1:0] host_word,
    input  logic          cpu_post,
    input  logic [HW-1:0] cpu_word,
    input  logic          cpu_ack,
    output logic [HW-1:0] out_word,
    output logic          out_full,
    output logic [HW-1:0] in_word,
    output logic          in_full,
    output logic          in_stb
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_word <= '0;
            out_full <= 1'b0;
        end else if (cpu_post) begin
            out_word <= cpu_word;
            out_full <= 1'b1;
        end else if (host_rd_ev) begin
            out_full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_word <= '0;
            in_full <= 1'b0;
            in_stb  <= 1'b0;
        end else begin
            in_stb <= host_wr_ev;
            if (host_wr_ev) begin
                in_word <= host_word;
                in_full <= 1'b1;
            end else if (cpu_ack) begin
                in_full <= 1'b0;
            end
        end
    end

    a_r7_post_sets_full: assert property (@(posedge clk) disable iff (rst)
        cpu_post |=> out_full && out_word == $past(cpu_word));
    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (host_rd_ev && !cpu_post) |=> !out_full);
    a_r9_in_full: assert property (@(posedge clk) disable iff (rst)
        host_wr_ev |=> in_full && in_stb);
    a_r9_stb_one_cycle: assert property (@(posedge clk) disable iff (rst)
        in_stb |=> !in_stb);
endmodule

// File: rtl/hpb_mem_port.sv
module hpb_mem_port
    import hpb_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           data_rd_ev,
    input  logic           data_wr_ev,
    input  logic           ptr_wr_ev,
    input  logic [HW-1:0]  ptr_value,
    input  logic [HW-1:0]  store_word,
    output logic [HW-1:0]  ptr,
    output logic [HW-1:0]  fetch_buf,
    output logic           busy,
    output logic           mem_req,
    output logic           mem_we,
    output logic [MAW-1:0] mem_addr,
    output logic [HW-1:0]  mem_wdata,
    input  logic [HW-1:0]  mem_rdata,
    input  logic           mem_gnt
);
    mp_state_e     state;
    logic [HW-1:0] wr_hold;
    localparam logic [HW-1:0] STEP = HW'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= MP_IDLE;
            ptr       <= '0;
            fetch_buf <= '0;
            wr_hold   <= '0;
        end else begin
            unique case (state)
                MP_IDLE: begin
                    if (ptr_wr_ev) begin
                        ptr   <= ptr_value;
                        state <= MP_FETCH;
                    end else if (data_wr_ev) begin
                        wr_hold <= store_word;
                        state   <= MP_WRITE;
                    end else if (data_rd_ev) begin
                        ptr   <= ptr + STEP;
                        state <= MP_FETCH;
                    end
                end
                MP_WRITE: begin
                    if (mem_gnt) begin
                        ptr   <= ptr + STEP;
                        state <= MP_FETCH;
                    end
                end
                MP_FETCH: begin
                    if (mem_gnt) begin
                        fetch_buf <= mem_rdata;
                        state     <= MP_IDLE;
                    end
                end
                default: state <= MP_IDLE;
            endcase
        end
    end

    assign busy      = (state != MP_IDLE);
    assign mem_req   = (state != MP_IDLE);
    assign mem_we    = (state == MP_WRITE);
    assign mem_addr  = ptr[HW-1:1];
    assign mem_wdata = wr_hold;

    a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    a_r4_write_step: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_gnt) |=> ptr == $past(ptr) + STEP);
    a_r5_read_step: assert property (@(posedge clk) disable iff (rst)
        (data_rd_ev && !ptr_wr_ev && !data_wr_ev && !busy) |=> mem_req && !mem_we && ptr == $past(ptr) + STEP);
endmodule

// File: rtl/hostport_bridge.sv
module hostport_bridge
    import hpb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           host_cs_n,
    input  logic           host_rd_n,
    input  logic           host_wr_n,
    input  logic [1:0]     host_addr,
    input  logic [HW-1:0]  host_wdata,
    output logic [HW-1:0]  host_rdata,
    output logic           host_int,
    input  logic           swap_en,
    output logic           mem_req,
    output logic           mem_we,
    output logic [MAW-1:0] mem_addr,
    output logic [HW-1:0]  mem_wdata,
    input  logic [HW-1:0]  mem_rdata,
    input  logic           mem_gnt,
    input  logic           cpu_out_wr,
    input  logic [HW-1:0]  cpu_out_data,
    output logic [HW-1:0]  cpu_in_word,
    output logic           cpu_in_stb,
    input  logic           cpu_in_ack
);
    hpb_strobe_t   strobe;
    hpb_event_t    ev;
    hpb_sel_e      sel;
    logic [HW-1:0] ptr, fetch_buf, out_word, rdata_q;
    logic          busy, out_full, in_full;

    assign strobe = '{cs_n: host_cs_n, rd_n: host_rd_n, wr_n: host_wr_n};
    assign sel    = hpb_sel_e'(host_addr);

    hpb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .strobe_in(strobe), .ev(ev)
    );

    hpb_mem_port u_mem (
        .clk(clk), .rst(rst),
        .data_rd_ev(ev.rd && sel == SEL_DATA),
        .data_wr_ev(ev.wr && sel == SEL_DATA),
        .ptr_wr_ev(ev.wr && sel == SEL_PTR),
        .ptr_value(host_wdata),
        .store_word(lane_swap(host_wdata, swap_en)),
        .ptr(ptr), .fetch_buf(fetch_buf), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_gnt(mem_gnt)
    );

    hpb_mailbox u_mbx (
        .clk(clk), .rst(rst),
        .host_rd_ev(ev.rd && sel == SEL_MBX),
        .host_wr_ev(ev.wr && sel == SEL_MBX),
        .host_word(host_wdata),
        .cpu_post(cpu_out_wr), .cpu_word(cpu_out_data), .cpu_ack(cpu_in_ack),
        .out_word(out_word), .out_full(out_full),
        .in_word(cpu_in_word), .in_full(in_full), .in_stb(cpu_in_stb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (ev.rd) begin
            unique case (sel)
                SEL_DATA: rdata_q <= lane_swap(fetch_buf, swap_en);
                SEL_MBX:  rdata_q <= out_word;
                SEL_PTR:  rdata_q <= ptr;
                SEL_STAT: rdata_q <= status_word(out_full, in_full);
                default:  rdata_q <= '0;
            endcase
        end
    end

    assign host_rdata = rdata_q;
    assign host_int   = out_full;

    a_r6_status_no_side_effect: assert property (@(posedge clk) disable iff (rst)
        (ev.rd && !ev.wr && (sel == SEL_STAT || sel == SEL_PTR) && !busy) |=> $stable(ptr));
    a_r7_int_follows_post: assert property (@(posedge clk) disable iff (rst)
        cpu_out_wr |=> host_int);
    a_r1_no_req_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> !mem_req && !host_int);
endmodule

// File: tb/tb_hostport_bridge.sv
module tb_hostport_bridge;
    import hpb_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic           rst;
    logic           host_cs_n, host_rd_n, host_wr_n;
    logic [1:0]     host_addr;
    logic [HW-1:0]  host_wdata, host_rdata;
    logic           host_int, swap_en;
    logic           mem_req, mem_we, mem_gnt;
    logic [MAW-1:0] mem_addr;
    logic [HW-1:0]  mem_wdata, mem_rdata;
    logic           cpu_out_wr, cpu_in_stb, cpu_in_ack;
    logic [HW-1:0]  cpu_out_data, cpu_in_word;

    hostport_bridge dut (.*);

    // memory model with programmable grant latency
    logic [HW-1:0] mem [256];
    int            lat = 0;
    int            gcnt = 0;
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) begin
        mem_gnt <= 1'b0;
        if (mem_req && !mem_gnt) begin
            if (gcnt >= lat) begin mem_gnt <= 1'b1; gcnt <= 0; end
            else gcnt <= gcnt + 1;
        end
        if (mem_req && mem_we && mem_gnt) mem[mem_addr[7:0]] <= mem_wdata;
    end

    int stb_cnt = 0;
    always @(posedge clk) if (!rst && cpu_in_stb) stb_cnt <= stb_cnt + 1;

    int n_checks = 0, n_fail = 0, cycles = 0;

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    task automatic check(string req, logic [HW-1:0] act, logic [HW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hwrite(logic [1:0] a, logic [HW-1:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_cs_n = 0; host_wr_n = 0;
        idle(8);
        host_cs_n = 1; host_wr_n = 1;
        idle(14);
    endtask

    task automatic hread(logic [1:0] a, output logic [HW-1:0] d, input int hold = 8);
        @(negedge clk);
        host_addr = a; host_cs_n = 0; host_rd_n = 0;
        idle(hold);
        d = host_rdata;
        host_cs_n = 1; host_rd_n = 1;
        idle(14);
    endtask

    // vector table: {is_write, addr, data, expected}
    localparam int NV = 12;
    localparam logic [34:0] VEC [NV] = '{
        {1'b1, 2'b10, 16'h0010, 16'h0000},  // R2 pointer load
        {1'b1, 2'b00, 16'h1111, 16'h0000},  // R4 stream write
        {1'b1, 2'b00, 16'h2222, 16'h0000},
        {1'b1, 2'b00, 16'h3333, 16'h0000},
        {1'b0, 2'b10, 16'h0000, 16'h0016},  // R4 pointer after three writes
        {1'b1, 2'b10, 16'h0010, 16'h0000},  // R5 reload triggers fetch
        {1'b0, 2'b00, 16'h0000, 16'h1111},  // R5 stream read
        {1'b0, 2'b00, 16'h0000, 16'h2222},
        {1'b0, 2'b11, 16'h0000, 16'h0000},  // R6 status read
        {1'b0, 2'b10, 16'h0000, 16'h0014},  // R6 pointer unchanged by status read
        {1'b0, 2'b10, 16'h0000, 16'h0014},  // R6 pointer read has no effect
        {1'b0, 2'b00, 16'h0000, 16'h3333}   // R5 next word
    };

    initial begin
        logic [HW-1:0] r;
        host_cs_n = 1; host_rd_n = 1; host_wr_n = 1;
        host_addr = 0; host_wdata = 0; swap_en = 0;
        cpu_out_wr = 0; cpu_out_data = 0; cpu_in_ack = 0;
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3);
        rst = 1;
        idle(5);
        rst = 0;
        idle(3);

        // R1 reset state
        check("R1 rdata", host_rdata, 16'h0000);
        check("R1 int", {15'b0, host_int}, 16'h0000);
        check("R1 req", {15'b0, mem_req}, 16'h0000);
        hread(2'b11, r);
        check("R1 status", r, 16'h0000);

        // table walk (R2 R4 R5 R6)
        lat = 2;
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][34]) hwrite(VEC[i][33:32], VEC[i][31:16]);
            else begin
                hread(VEC[i][33:32], r);
                check($sformatf("R5 vector %0d", i), r, VEC[i][15:0]);
            end
        end
        check("R4 memory word 8", mem[8], 16'h1111);
        check("R4 memory word 10", mem[10], 16'h3333);
        lat = 0;

        // R3 strobe without chip select is ignored
        @(negedge clk);
        host_addr = 2'b10; host_wdata = 16'h0BAD; host_wr_n = 0;
        idle(8); host_wr_n = 1; idle(10);
        hread(2'b10, r);
        check("R3 no cs", r, 16'h0016);
        // R3 long strobe gives one access
        hread(2'b00, r, 40);
        check("R3 long read data", r, mem[11]);
        hread(2'b10, r);
        check("R3 long read step", r, 16'h0018);

        // R7 / R8 outgoing mailbox
        @(negedge clk); cpu_out_data = 16'hC0DE; cpu_out_wr = 1;
        @(negedge clk); cpu_out_wr = 0;
        check("R7 int", {15'b0, host_int}, 16'h0001);
        hread(2'b11, r);
        check("R7 status bit0", r, 16'h0001);
        hread(2'b01, r);
        check("R8 mailbox word", r, 16'hC0DE);
        check("R8 int cleared", {15'b0, host_int}, 16'h0000);
        hread(2'b11, r);
        check("R8 status cleared", r, 16'h0000);

        // R9 incoming mailbox
        hwrite(2'b01, 16'hBEEF);
        check("R9 word", cpu_in_word, 16'hBEEF);
        check("R9 one strobe", 16'(stb_cnt), 16'd1);
        hread(2'b11, r);
        check("R9 status bit1", r, 16'h0002);
        @(negedge clk); cpu_in_ack = 1;
        @(negedge clk); cpu_in_ack = 0;
        hread(2'b11, r);
        check("R9 ack clears", r, 16'h0000);

        // R10 byte swap
        swap_en = 1;
        hwrite(2'b10, 16'h0020);
        hwrite(2'b00, 16'h1234);
        check("R10 swapped store", mem[16], 16'h3412);
        hwrite(2'b10, 16'h0020);
        hread(2'b00, r);
        check("R10 swapped load", r, 16'h1234);
        swap_en = 0;
        hwrite(2'b10, 16'h0020);
        hread(2'b00, r);
        check("R10 plain load", r, 16'h3412);

        // R11 wrap
        hwrite(2'b10, 16'hFFFE);
        hwrite(2'b00, 16'h5555);
        hread(2'b10, r);
        check("R11 wrap", r, 16'h0000);
        check("R11 top word", mem[255], 16'h5555);

        finish_run();
    end
endmodule